// File: doc/BRIEF.md
# Priority-First Round-Robin Output Arbiter

This block decides, for one output port of an unbuffered crossbar, which of eight input buffers may move its head packet into that port's output queue. Each input offers a request made of three parts: a valid bit, a bit saying that the packet is routed to this output, and a 2-bit urgency level. Because the crossbar has no storage of its own, a packet may only be granted when the output queue will take it. The queue takes a packet when it is not full and the packet's urgency is at least the queue fill level minus a fixed slack of four.

Among the inputs that pass this check, only those at the highest urgency present compete. A single rotating pointer, shared by all urgency levels, breaks ties. The winner receives a registered one-hot grant. The grant stays asserted until the crossbar datapath reports with `move_done` that the packet has crossed. The arbiter then drops the grant, moves the pointer one past the winner and pulses `push_strobe` for one cycle. A fresh arbitration starts in the cycle after that.

Top module: `prio_rr_out_arbiter`

## Requirements
- R1: An input is a candidate only when both its `req_valid` bit and its `req_dest_match` bit are 1.
- R2: A candidate is admitted only when `out_fill` is below 8 and its urgency plus 4 is at least `out_fill`. With `out_fill` equal to 8, no grant is ever issued.
- R3: Input i's urgency sits at `req_prio[2i+1:2i]`, and 3 is the most urgent. Only admitted candidates at the highest urgency among admitted candidates can win.
- R4: Among the tied winners, the grant goes to the first one found when scanning upward from the pointer and wrapping from input 7 to input 0.
- R5: When a transfer completes, the pointer becomes (winner + 1) mod 8. It changes at no other time.
- R6: `grant` is at most one-hot. A grant appears at the first clock edge at which the arbiter is idle and an admitted candidate exists.
- R7: While a grant is held and `move_done` is 0, `grant` stays unchanged. Changes on the request inputs have no effect on it.
- R8: At the clock edge where `move_done` is 1 while a grant is held, `grant` clears and `push_strobe` is 1 for exactly the following cycle. The next grant can appear at the edge after that, at the earliest.
- R9: When no input is admitted, no grant is issued and the pointer keeps its value.
- R10: A synchronous active-high `rst` clears `grant` and `push_strobe`, and returns the pointer to input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 8 | Per-input head packet present |
| req_dest_match | input | 8 | Per-input head packet routed to this output |
| req_prio | input | 16 | Per-input urgency, 2 bits each, input i at [2i+1:2i] |
| out_fill | input | 4 | Current occupancy of the output queue, 0 to 8 |
| move_done | input | 1 | Crossbar reports that the granted packet has crossed |
| grant | output | 8 | One-hot grant to the winning input |
| push_strobe | output | 1 | One-cycle pulse after a completed transfer |

## Verification
Two events can fall in the same cycle: a transfer completes, and a new, more urgent request arrives. The bench changes the request to a top-urgency input while a grant is held, and keeps it present through the cycle in which `move_done` is raised. At the completion edge the old grant must clear and the strobe must rise, with no new grant yet. The new grant must appear one edge later. A separate sequence of tie rounds tracks the pointer as it moves across completions, across wrap-around and across rounds that issue no grant.

// File: rtl/prio_rr_arb_pkg.sv
package prio_rr_arb_pkg;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

    // Output queue admission: room left and urgency high enough for the fill level.
    function automatic logic queue_admits(input int unsigned prio,
                                          input int unsigned fill,
                                          input int unsigned depth,
                                          input int unsigned slack);
        return (fill < depth) && ((prio + slack) >= fill);
    endfunction

    // Index one past idx, wrapping at n.
    function automatic int unsigned wrap_next(input int unsigned idx,
                                              input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/prio_level_filter.sv
module prio_level_filter
    import prio_rr_arb_pkg::*;
#(
    parameter int N_REQ   = 8,
    parameter int PRIO_W  = 2,
    parameter int FILL_W  = 4,
    parameter int Q_DEPTH = 8,
    parameter int SLACK   = 4
) (
    input  logic [N_REQ-1:0]        valid_i,
    input  logic [N_REQ-1:0]        match_i,
    input  logic [N_REQ*PRIO_W-1:0] prio_i,
    input  logic [FILL_W-1:0]       fill_i,
    output logic [N_REQ-1:0]        top_mask_o
);

    logic [PRIO_W-1:0] lvl [N_REQ];
    logic [N_REQ-1:0]  admitted;
    logic [PRIO_W-1:0] best_lvl;

    for (genvar g = 0; g < N_REQ; g++) begin : g_req
        assign lvl[g]      = prio_i[g*PRIO_W +: PRIO_W];
        assign admitted[g] = valid_i[g] && match_i[g] &&
                             queue_admits(32'(lvl[g]), 32'(fill_i), Q_DEPTH, SLACK);
    end

    always_comb begin
        best_lvl = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (admitted[i] && (lvl[i] > best_lvl)) begin
                best_lvl = lvl[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < N_REQ; i++) begin
            top_mask_o[i] = admitted[i] && (lvl[i] == best_lvl);
        end
    end

endmodule

// File: rtl/rr_pointer_pick.sv
module rr_pointer_pick #(
    parameter int N_REQ = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_REQ-1:0] mask_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [N_REQ-1:0] pick_o,
    output logic [IDX_W-1:0] pick_idx_o,
    output logic             found_o
);

    logic [IDX_W-1:0] probe;

    always_comb begin
        pick_o     = '0;
        pick_idx_o = '0;
        found_o    = 1'b0;
        probe      = '0;
        for (int k = 0; k < N_REQ; k++) begin
            probe = IDX_W'((32'(ptr_i) + 32'(k)) % N_REQ);
            if (!found_o && mask_i[probe]) begin
                found_o       = 1'b1;
                pick_o[probe] = 1'b1;
                pick_idx_o    = probe;
            end
        end
    end

endmodule

// File: rtl/prio_rr_out_arbiter.sv
module prio_rr_out_arbiter
    import prio_rr_arb_pkg::*;
#(
    parameter int N_REQ   = 8,
    parameter int PRIO_W  = 2,
    parameter int Q_DEPTH = 8,
    parameter int SLACK   = 4,
    localparam int FILL_W = $clog2(Q_DEPTH + 1),
    localparam int IDX_W  = $clog2(N_REQ)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [N_REQ-1:0]        req_valid,
    input  logic [N_REQ-1:0]        req_dest_match,
    input  logic [N_REQ*PRIO_W-1:0] req_prio,
    input  logic [FILL_W-1:0]       out_fill,
    input  logic                    move_done,
    output logic [N_REQ-1:0]        grant,
    output logic                    push_strobe
);

    arb_state_e       state_q;
    logic [N_REQ-1:0] grant_q;
    logic [IDX_W-1:0] win_idx_q;
    logic [IDX_W-1:0] ptr_q;
    logic             push_q;

    logic [N_REQ-1:0] top_mask;
    logic [N_REQ-1:0] pick;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_found;

    prio_level_filter #(
        .N_REQ  (N_REQ),
        .PRIO_W (PRIO_W),
        .FILL_W (FILL_W),
        .Q_DEPTH(Q_DEPTH),
        .SLACK  (SLACK)
    ) filter_i (
        .valid_i   (req_valid),
        .match_i   (req_dest_match),
        .prio_i    (req_prio),
        .fill_i    (out_fill),
        .top_mask_o(top_mask)
    );

    rr_pointer_pick #(
        .N_REQ(N_REQ),
        .IDX_W(IDX_W)
    ) picker_i (
        .mask_i    (top_mask),
        .ptr_i     (ptr_q),
        .pick_o    (pick),
        .pick_idx_o(pick_idx),
        .found_o   (pick_found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ARB_IDLE;
            grant_q   <= '0;
            win_idx_q <= '0;
            ptr_q     <= '0;
            push_q    <= 1'b0;
        end else begin
            push_q <= 1'b0;
            case (state_q)
                ARB_IDLE: begin
                    if (pick_found) begin
                        state_q   <= ARB_HOLD;
                        grant_q   <= pick;
                        win_idx_q <= pick_idx;
                    end
                end
                ARB_HOLD: begin
                    if (move_done) begin
                        state_q <= ARB_IDLE;
                        grant_q <= '0;
                        ptr_q   <= IDX_W'(wrap_next(32'(win_idx_q), N_REQ));
                        push_q  <= 1'b1;
                    end
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign grant       = grant_q;
    assign push_strobe = push_q;

    // R6
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_q));

    // R7
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_HOLD && !move_done) |=> $stable(grant_q));

    // R5
    ptr_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ARB_HOLD && move_done) |=> $stable(ptr_q));

    // R8
    push_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        push_q |-> $past(state_q == ARB_HOLD && move_done));

    // R2
    full_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ARB_IDLE && out_fill >= FILL_W'(Q_DEPTH)) |=> (grant_q == '0));

endmodule

// File: tb/prio_rr_out_arbiter_tb.sv
module prio_rr_out_arbiter_tb_top;

    typedef struct packed {
        logic [7:0]  v;
        logic [7:0]  m;
        logic [15:0] p;
        logic [3:0]  fill;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{8'h0F, 8'hFF, 16'h0000, 4'd0, 8'h01},
        '{8'h0F, 8'hFF, 16'h0000, 4'd0, 8'h02},
        '{8'h81, 8'hFF, 16'hC000, 4'd0, 8'h80},
        '{8'hFF, 8'hFF, 16'h5965, 4'd0, 8'h04},
        '{8'hFF, 8'hFF, 16'h5965, 4'd0, 8'h20},
        '{8'hFF, 8'hFF, 16'h5965, 4'd0, 8'h04},
        '{8'hFF, 8'h0F, 16'h5965, 4'd0, 8'h04},
        '{8'hFF, 8'hFF, 16'h3201, 4'd6, 8'h40},
        '{8'h11, 8'hFF, 16'h0203, 4'd7, 8'h01},
        '{8'hFF, 8'hFF, 16'hFFFF, 4'd8, 8'h00},
        '{8'h03, 8'hFF, 16'h0000, 4'd5, 8'h00},
        '{8'h0C, 8'hFF, 16'h0050, 4'd5, 8'h04},
        '{8'h06, 8'hFF, 16'h0000, 4'd0, 8'h02},
        '{8'h00, 8'hFF, 16'h0000, 4'd0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  req_valid = '0;
    logic [7:0]  req_dest_match = '0;
    logic [15:0] req_prio = '0;
    logic [3:0]  out_fill = '0;
    logic        move_done = 1'b0;
    logic [7:0]  grant;
    logic        push_strobe;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    prio_rr_out_arbiter dut_i (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_dest_match(req_dest_match),
        .req_prio      (req_prio),
        .out_fill      (out_fill),
        .move_done     (move_done),
        .grant         (grant),
        .push_strobe   (push_strobe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            1, 4, 5, 12: return "R4/R5 tie rotation";
            2:           return "R3 top urgency";
            3:           return "R3/R4 tied top level";
            6:           return "R1 destination mask";
            7, 8, 11:    return "R2 admission slack";
            9:           return "R2 queue full";
            10, 13:      return "R9 nothing admitted";
            default:     return "R6 basic grant";
        endcase
    endfunction

    task automatic run_vec(input vec_t vv, input int idx);
        @(negedge clk);
        req_valid = vv.v; req_dest_match = vv.m; req_prio = vv.p; out_fill = vv.fill;
        move_done = 1'b0;
        @(negedge clk);
        check($sformatf("%s vec %0d grant", vec_tag(idx), idx), 32'(grant), 32'(vv.exp));
        req_valid = '0;
        if (vv.exp != 0) begin
            move_done = 1'b1;
            @(negedge clk);
            check("R8 grant clears on completion", 32'(grant), 32'h0);
            check("R8 strobe after completion", 32'(push_strobe), 32'h1);
            move_done = 1'b0;
            @(negedge clk);
            check("R8 strobe lasts one cycle", 32'(push_strobe), 32'h0);
        end else begin
            @(negedge clk);
            check("R9 still no grant", 32'(grant), 32'h0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        check("R10 reset grant", 32'(grant), 32'h0);
        check("R10 reset strobe", 32'(push_strobe), 32'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], i);
        end

        // Hold, then a more urgent arrival while completing in the same cycle. Pointer is 2.
        @(negedge clk);
        req_valid = 8'h01; req_dest_match = 8'hFF; req_prio = 16'h0000; out_fill = 4'd0;
        @(negedge clk);
        check("R6 grant issued", 32'(grant), 32'h01);
        req_valid = 8'h80; req_prio = 16'hC000;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            check("R7 grant held despite new request", 32'(grant), 32'h01);
            check("R7 no strobe while held", 32'(push_strobe), 32'h0);
        end
        move_done = 1'b1;
        @(negedge clk);
        check("R8 same-cycle completion clears grant", 32'(grant), 32'h0);
        check("R8 same-cycle completion strobe", 32'(push_strobe), 32'h1);
        move_done = 1'b0;
        @(negedge clk);
        check("R8 new grant one edge later", 32'(grant), 32'h80);
        check("R8 strobe dropped", 32'(push_strobe), 32'h0);
        req_valid = '0;
        move_done = 1'b1;
        @(negedge clk);
        move_done = 1'b0;

        // Pointer is 0: grant input 1, complete, so pointer moves to 2.
        req_valid = 8'h02; req_prio = 16'h0000;
        @(negedge clk);
        check("R6 grant input 1", 32'(grant), 32'h02);
        req_valid = '0;
        move_done = 1'b1;
        @(negedge clk);
        move_done = 1'b0;
        req_valid = 8'h08;
        @(negedge clk);
        check("R6 grant input 3", 32'(grant), 32'h08);
        req_valid = '0;
        rst = 1'b1;
        @(negedge clk);
        check("R10 reset clears held grant", 32'(grant), 32'h0);
        check("R10 reset clears strobe", 32'(push_strobe), 32'h0);
        rst = 1'b0;
        req_valid = 8'h0F;
        @(negedge clk);
        check("R10 pointer back to input 0", 32'(grant), 32'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule